// File: doc/BRIEF.md
# Resistive Touch Panel Scan Sequencer

This block drives an external resistive-touch ADC over a four-wire SPI link and produces one complete touch sample per scan. A scan starts on a one-cycle start pulse or when the active-low pen interrupt has stayed low long enough to count as a real touch. During the scan, chip select stays low across four conversion frames, taken in a fixed order: Y, X, Z1 and then Z2. Each frame is 16 serial clocks long. The first eight clocks carry a control byte and the last eight carry an all-zero filler byte. Meanwhile the ADC answers on MISO, and a 12-bit result is taken from a skewed bit position across the two received bytes.

The first three frames ask the ADC to keep its reference and converter powered, which masks the pen interrupt. The final Z2 frame asks for power-down between conversions, which arms the pen interrupt again. When the scan ends, the four results and a pressed flag are loaded into output registers. The registers raise a valid flag, and a done pulse marks the load. They hold their contents until the consumer accepts them with ready. A request that arrives while a result is still waiting is dropped, and it sets an overflow flag.

Top module: `touch_scan_seq`

## Requirements
- R1: After reset, cs_n is 1, sclk is 0, res_valid is 0, overflow is 0, scan_done is 0 and all result outputs are 0.
- R2: A start_i pulse while idle starts one scan: cs_n goes low, 64 rising sclk edges follow (four frames of 16), and then cs_n returns high.
- R3: The control byte is sent MSB first as {start=1, mux[2:0], mode, ref, pd[1:0]}. The mode bit is 0 for 12-bit and the ref bit is 0 for differential. The mux codes are Y=001, X=101, Z1=011 and Z2=100. The first three frames use pd=11 and the Z2 frame uses pd=00, so the frames carry 0x93, 0xD3, 0xB3 and 0xC0 in that order. The eight clocks after each control byte shift out zeros.
- R4: sclk idles low. MOSI changes only while sclk is low, and MISO is sampled on the rising edge. Each sclk high and low phase within a frame lasts exactly SCLK_HALF system clocks. A parameter set giving an sclk above 2.0 MHz is rejected at elaboration.
- R5: Let the two bytes received in a frame be F (first) and S (second). The 12-bit result is ((F & 0x7F) << 5) | (S >> 3). Frames 1 to 4 feed res_y, res_x, res_z1 and res_z2.
- R6: res_pressed is 1 exactly when z1 is nonzero and X_MIN <= x <= X_MAX. When it is 0, res_x and res_y keep their previous values, while res_z1 and res_z2 still update.
- R7: res_valid rises in the same cycle as a one-cycle scan_done pulse. While res_valid is 1 and res_ready is 0, the outputs hold steady. res_valid falls in the cycle after a cycle in which both res_valid and res_ready are 1.
- R8: pen_irq_n passes through two synchronizing flops. A scan starts only after the synchronized level has been low for DEBOUNCE_CYCLES consecutive cycles. A shorter low pulse starts nothing.
- R9: While a scan is running, start_i and pen_irq_n have no effect. No second scan follows.
- R10: A start request made while res_valid is 1 is dropped (no scan) and sets overflow. overflow clears when the pending result is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | One-cycle scan request |
| pen_irq_n | input | 1 | Asynchronous active-low pen-down signal from the ADC |
| sclk | output | 1 | Serial clock to the ADC |
| cs_n | output | 1 | Active-low ADC select, held low for a whole scan |
| mosi | output | 1 | Serial command data to the ADC |
| miso | input | 1 | Serial conversion data from the ADC |
| res_valid | output | 1 | A result set is waiting to be taken |
| res_ready | input | 1 | Consumer accepts the waiting result |
| res_x | output | RES_W | X position result |
| res_y | output | RES_W | Y position result |
| res_z1 | output | RES_W | First pressure result |
| res_z2 | output | RES_W | Second pressure result |
| res_pressed | output | 1 | Sample counts as a valid touch |
| scan_done | output | 1 | One-cycle pulse when a result set is loaded |
| overflow | output | 1 | A request was dropped while a result was pending |

## Verification
The hardest cases to reach are a request that lands while the sequencer is busy and one that lands while a result is still unaccepted. Both are timing windows that only open partway through a scan. The bench waits for chip select to fall and then holds the pen line low for longer than the debounce window, and it also fires extra start pulses before the scan ends. In another test it deliberately leaves a finished result unaccepted and then issues a new start. The ADC model encodes each 12-bit value with ones in the bits that must be discarded, so that extraction and masking are both checked.

// File: rtl/tsc_pkg.sv
// Shared definitions for the touch scan sequencer: channel order, command
// byte layout and ADC mux/power codes. Assumes a 12-bit result format.
package tsc_pkg;

    localparam int CMD_W      = 8;
    localparam int FRAME_BITS = 2 * CMD_W;
    localparam int RES_W      = 12;
    localparam int NUM_CH     = 4;

    // Channel visiting order within one scan
    typedef enum logic [1:0] {
        CH_Y  = 2'd0,
        CH_X  = 2'd1,
        CH_Z1 = 2'd2,
        CH_Z2 = 2'd3
    } chan_e;

    localparam logic [1:0] PWR_KEEP_ON  = 2'b11;  // pen interrupt masked
    localparam logic [1:0] PWR_SLEEP    = 2'b00;  // pen interrupt armed
    localparam logic       MODE_12BIT   = 1'b0;
    localparam logic       REF_DIFF     = 1'b0;

    // Mux selection for each channel
    function automatic logic [2:0] mux_code(chan_e ch);
        case (ch)
            CH_Y:    mux_code = 3'b001;
            CH_X:    mux_code = 3'b101;
            CH_Z1:   mux_code = 3'b011;
            default: mux_code = 3'b100;
        endcase
    endfunction

    // Assemble a command byte: start bit on top, power code at the bottom
    function automatic logic [CMD_W-1:0] cmd_byte(chan_e ch, logic [1:0] pwr);
        cmd_byte = {1'b1, mux_code(ch), MODE_12BIT, REF_DIFF, pwr};
    endfunction

endpackage

// File: rtl/tsc_pen_filter.sv
// Pen-down qualifier. Synchronizes the asynchronous active-low pen line with
// two flops and emits a one-cycle request once the synchronized level has
// been low for DEBOUNCE_CYCLES consecutive enabled cycles. The counter is
// cleared whenever the pen is high or the filter is disabled (scan running).
module tsc_pen_filter #(
    parameter int DEBOUNCE_CYCLES = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic pen_n_async,
    output logic pen_req
);
    localparam int CNT_W = $clog2(DEBOUNCE_CYCLES + 1);

    logic             sync_a;
    logic             sync_b;
    logic [CNT_W-1:0] low_cnt;

    // Two-flop synchronizer, idles high (pen up)
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_a <= 1'b1;
            sync_b <= 1'b1;
        end else begin
            sync_a <= pen_n_async;
            sync_b <= sync_a;
        end
    end

    // Count consecutive low cycles and fire when the window is reached
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            low_cnt <= '0;
            pen_req <= 1'b0;
        end else begin
            pen_req <= 1'b0;
            if (!enable || sync_b) begin
                low_cnt <= '0;
            end else if (low_cnt == CNT_W'(DEBOUNCE_CYCLES - 1)) begin
                low_cnt <= '0;
                pen_req <= 1'b1;
            end else begin
                low_cnt <= low_cnt + 1'b1;
            end
        end
    end

endmodule

// File: rtl/tsc_spi_frame.sv
// One 16-clock SPI conversion frame: shifts out the command byte followed by
// a zero filler byte, samples MISO on each rising sclk edge and returns the
// 12-bit result from the skewed position across the two received bytes.
// Assumes chip select is handled by the caller; sclk idles low.
module tsc_spi_frame
    import tsc_pkg::*;
#(
    parameter int SCLK_HALF = 63
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             launch,
    input  logic [CMD_W-1:0] cmd,
    input  logic             miso,
    output logic             sclk,
    output logic             mosi,
    output logic             frame_done,
    output logic [RES_W-1:0] conv_result
);
    localparam int DIV_W = (SCLK_HALF > 1) ? $clog2(SCLK_HALF) : 1;
    localparam int BIT_W = $clog2(FRAME_BITS);

    logic                  busy;
    logic [DIV_W-1:0]      div_cnt;
    logic [BIT_W-1:0]      bit_cnt;
    logic [FRAME_BITS-1:0] tx_sh;
    logic [FRAME_BITS-2:0] rx_sh;   // first received bit is never needed

    // Frame engine: divider, edge generation, shift and sample
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy       <= 1'b0;
            div_cnt    <= '0;
            bit_cnt    <= '0;
            tx_sh      <= '0;
            rx_sh      <= '0;
            sclk       <= 1'b0;
            frame_done <= 1'b0;
        end else begin
            frame_done <= 1'b0;
            if (launch && !busy) begin
                busy    <= 1'b1;
                tx_sh   <= {cmd, {CMD_W{1'b0}}};
                div_cnt <= '0;
                bit_cnt <= '0;
                sclk    <= 1'b0;
            end else if (busy) begin
                if (div_cnt == DIV_W'(SCLK_HALF - 1)) begin
                    div_cnt <= '0;
                    if (!sclk) begin
                        sclk  <= 1'b1;
                        rx_sh <= {rx_sh[FRAME_BITS-3:0], miso};
                    end else begin
                        sclk <= 1'b0;
                        if (bit_cnt == BIT_W'(FRAME_BITS - 1)) begin
                            busy       <= 1'b0;
                            frame_done <= 1'b1;
                        end else begin
                            bit_cnt <= bit_cnt + 1'b1;
                            tx_sh   <= {tx_sh[FRAME_BITS-2:0], 1'b0};
                        end
                    end
                end else begin
                    div_cnt <= div_cnt + 1'b1;
                end
            end
        end
    end

    // Output bit and result extraction: low 7 bits of byte one, top 5 of byte two
    always_comb begin
        mosi        = tx_sh[FRAME_BITS-1];
        conv_result = {rx_sh[FRAME_BITS-2:CMD_W], rx_sh[CMD_W-1:3]};
    end

endmodule

// File: rtl/tsc_result_out.sv
// Output register stage: loads a finished scan, decides the pressed flag,
// holds coordinates when the sample is not a valid touch, and keeps the set
// until the consumer accepts it. Tracks dropped requests in a sticky flag.
module tsc_result_out
    import tsc_pkg::*;
#(
    parameter int X_MIN = 64,
    parameter int X_MAX = 4031
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [RES_W-1:0] raw_x,
    input  logic [RES_W-1:0] raw_y,
    input  logic [RES_W-1:0] raw_z1,
    input  logic [RES_W-1:0] raw_z2,
    input  logic             drop,
    input  logic             ready,
    output logic             valid,
    output logic [RES_W-1:0] x,
    output logic [RES_W-1:0] y,
    output logic [RES_W-1:0] z1,
    output logic [RES_W-1:0] z2,
    output logic             pressed,
    output logic             done,
    output logic             ovf
);
    logic touch_ok;

    // Touch qualification on the incoming raw set
    always_comb begin
        touch_ok = (raw_z1 != '0) && (raw_x >= RES_W'(X_MIN)) && (raw_x <= RES_W'(X_MAX));
    end

    // Result registers with valid/ready hold and overflow tracking
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid   <= 1'b0;
            x       <= '0;
            y       <= '0;
            z1      <= '0;
            z2      <= '0;
            pressed <= 1'b0;
            done    <= 1'b0;
            ovf     <= 1'b0;
        end else begin
            done <= load;
            if (load) begin
                valid   <= 1'b1;
                z1      <= raw_z1;
                z2      <= raw_z2;
                pressed <= touch_ok;
                if (touch_ok) begin
                    x <= raw_x;
                    y <= raw_y;
                end
            end else if (valid && ready) begin
                valid <= 1'b0;
                ovf   <= 1'b0;
            end
            if (drop) begin
                ovf <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/touch_scan_seq.sv
// Touch scan sequencer top. Arbitrates start/pen requests, holds chip select
// low across four conversion frames (Y, X, Z1, Z2), chooses the power code
// per frame (last frame re-arms the pen interrupt) and hands results to the
// output stage. Assumes SYS_CLK_HZ is the real frequency of clk.
module touch_scan_seq
    import tsc_pkg::*;
#(
    parameter int SYS_CLK_HZ      = 250_000_000,
    parameter int SCLK_HALF       = 63,
    parameter int DEBOUNCE_CYCLES = 1000,
    parameter int X_MIN           = 64,
    parameter int X_MAX           = 4031
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             pen_irq_n,
    output logic             sclk,
    output logic             cs_n,
    output logic             mosi,
    input  logic             miso,
    output logic             res_valid,
    input  logic             res_ready,
    output logic [RES_W-1:0] res_x,
    output logic [RES_W-1:0] res_y,
    output logic [RES_W-1:0] res_z1,
    output logic [RES_W-1:0] res_z2,
    output logic             res_pressed,
    output logic             scan_done,
    output logic             overflow
);
    localparam int SCLK_HZ     = SYS_CLK_HZ / (2 * SCLK_HALF);
    localparam int SCLK_HZ_MAX = 2_000_000;

    // Elaboration guard on the serial clock rate
    if (SCLK_HZ > SCLK_HZ_MAX) begin : g_rate_check
        $error("sclk rate above 2.0 MHz: raise SCLK_HALF");
    end

    typedef enum logic [1:0] {
        S_IDLE,
        S_LAUNCH,
        S_WAIT,
        S_FINISH
    } state_e;

    state_e           state;
    chan_e            chan;
    logic             pen_req;
    logic             req;
    logic             frame_launch;
    logic             frame_done;
    logic [CMD_W-1:0] cmd;
    logic [RES_W-1:0] conv_result;
    logic [RES_W-1:0] slot [NUM_CH];
    logic             drop;
    logic             load;

    tsc_pen_filter #(
        .DEBOUNCE_CYCLES (DEBOUNCE_CYCLES)
    ) u_pen (
        .clk         (clk),
        .rst_n       (rst_n),
        .enable      (state == S_IDLE),
        .pen_n_async (pen_irq_n),
        .pen_req     (pen_req)
    );

    // Request arbitration and command selection
    always_comb begin
        req          = (state == S_IDLE) && (start_i || pen_req);
        drop         = req && res_valid;
        frame_launch = (state == S_LAUNCH);
        load         = (state == S_FINISH);
        cmd          = cmd_byte(chan, (chan == CH_Z2) ? PWR_SLEEP : PWR_KEEP_ON);
    end

    // Scan sequencer: chip select, channel stepping and result capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= S_IDLE;
            chan  <= CH_Y;
            cs_n  <= 1'b1;
            for (int i = 0; i < NUM_CH; i++) slot[i] <= '0;
        end else begin
            case (state)
                S_IDLE: begin
                    if (req && !res_valid) begin
                        cs_n  <= 1'b0;
                        chan  <= CH_Y;
                        state <= S_LAUNCH;
                    end
                end
                S_LAUNCH: state <= S_WAIT;
                S_WAIT: begin
                    if (frame_done) begin
                        slot[chan] <= conv_result;
                        if (chan == CH_Z2) begin
                            cs_n  <= 1'b1;
                            state <= S_FINISH;
                        end else begin
                            chan  <= chan_e'(chan + 2'd1);
                            state <= S_LAUNCH;
                        end
                    end
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    tsc_spi_frame #(
        .SCLK_HALF (SCLK_HALF)
    ) u_frame (
        .clk         (clk),
        .rst_n       (rst_n),
        .launch      (frame_launch),
        .cmd         (cmd),
        .miso        (miso),
        .sclk        (sclk),
        .mosi        (mosi),
        .frame_done  (frame_done),
        .conv_result (conv_result)
    );

    tsc_result_out #(
        .X_MIN (X_MIN),
        .X_MAX (X_MAX)
    ) u_out (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (load),
        .raw_x   (slot[CH_X]),
        .raw_y   (slot[CH_Y]),
        .raw_z1  (slot[CH_Z1]),
        .raw_z2  (slot[CH_Z2]),
        .drop    (drop),
        .ready   (res_ready),
        .valid   (res_valid),
        .x       (res_x),
        .y       (res_y),
        .z1      (res_z1),
        .z2      (res_z2),
        .pressed (res_pressed),
        .done    (scan_done),
        .ovf     (overflow)
    );

endmodule

// File: rtl/tsc_checker.sv
// Protocol and output-stage checks for touch_scan_seq, bound to every instance.
module tsc_checker
    import tsc_pkg::*;
#(
    parameter int SCLK_HALF = 63,
    parameter int X_MIN     = 64,
    parameter int X_MAX     = 4031
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cs_n,
    input logic             sclk,
    input logic             mosi,
    input logic             res_valid,
    input logic             res_ready,
    input logic [RES_W-1:0] res_x,
    input logic [RES_W-1:0] res_y,
    input logic [RES_W-1:0] res_z1,
    input logic [RES_W-1:0] res_z2,
    input logic             res_pressed,
    input logic             scan_done,
    input logic             overflow
);
    localparam int RUN_W = $clog2(SCLK_HALF + 1) + 1;

    logic             sclk_q;
    logic [RUN_W-1:0] run;

    // Length of the current sclk level in system clocks, saturating
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_q <= 1'b0;
            run    <= '0;
        end else begin
            sclk_q <= sclk;
            if (sclk != sclk_q)               run <= RUN_W'(1);
            else if (run < RUN_W'(SCLK_HALF)) run <= run + 1'b1;
        end
    end

    assert_sclk_phase_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk != sclk_q) |-> (run >= RUN_W'(SCLK_HALF - 1)));

    assert_mosi_on_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $changed(mosi) |-> !sclk);

    assert_sclk_in_cs_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> !sclk);

    assert_hold_until_ready_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !res_ready) |=> (res_valid && $stable(res_x) && $stable(res_y)
                                       && $stable(res_z1) && $stable(res_z2)
                                       && $stable(res_pressed)));

    assert_valid_with_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(res_valid) |-> scan_done);

    assert_done_sets_valid_R7: assert property (@(posedge clk) disable iff (!rst_n)
        scan_done |-> res_valid);

    assert_pressed_rule_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_pressed) |-> ((res_z1 != '0) && (res_x >= RES_W'(X_MIN))
                                        && (res_x <= RES_W'(X_MAX))));

    assert_ovf_needs_pending_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(overflow) |-> $past(res_valid));

endmodule

bind touch_scan_seq tsc_checker #(
    .SCLK_HALF (SCLK_HALF),
    .X_MIN     (X_MIN),
    .X_MAX     (X_MAX)
) u_tsc_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .cs_n        (cs_n),
    .sclk        (sclk),
    .mosi        (mosi),
    .res_valid   (res_valid),
    .res_ready   (res_ready),
    .res_x       (res_x),
    .res_y       (res_y),
    .res_z1      (res_z1),
    .res_z2      (res_z2),
    .res_pressed (res_pressed),
    .scan_done   (scan_done),
    .overflow    (overflow)
);

// File: tb/touch_scan_seq_test.sv
`timescale 1ns/1ps
module touch_scan_seq_test;
    localparam int SCLK_HALF = 63;
    localparam int DEB       = 200;
    localparam int X_MIN     = 64;
    localparam int X_MAX     = 4031;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_i = 1'b0;
    logic pen_irq_n = 1'b1;
    logic miso = 1'b0;
    logic res_ready = 1'b0;
    logic sclk, cs_n, mosi, res_valid, res_pressed, scan_done, overflow;
    logic [11:0] res_x, res_y, res_z1, res_z2;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    touch_scan_seq #(
        .SYS_CLK_HZ      (250_000_000),
        .SCLK_HALF       (SCLK_HALF),
        .DEBOUNCE_CYCLES (DEB),
        .X_MIN           (X_MIN),
        .X_MAX           (X_MAX)
    ) uut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .pen_irq_n(pen_irq_n),
        .sclk(sclk), .cs_n(cs_n), .mosi(mosi), .miso(miso),
        .res_valid(res_valid), .res_ready(res_ready),
        .res_x(res_x), .res_y(res_y), .res_z1(res_z1), .res_z2(res_z2),
        .res_pressed(res_pressed), .scan_done(scan_done), .overflow(overflow)
    );

    // ---------------- ADC model ----------------
    logic [15:0] resp [4];
    logic [7:0]  cmd_cap [4];
    int bit_i = 0, frame_i = 0, rises = 0, pad_ones = 0, cs_falls = 0;
    realtime t_rise = 0, hi_min = 1.0e9, hi_max = 0;

    // Encode a 12-bit value with junk in the bits the block must discard
    function automatic logic [15:0] enc(logic [11:0] v);
        return {1'b1, v[11:5], v[4:0], 3'b101};
    endfunction

    always @(negedge cs_n) begin
        cs_falls++;
        bit_i = 0; frame_i = 0; rises = 0; pad_ones = 0;
        miso = resp[0][15];
    end

    always @(posedge sclk) begin
        t_rise = $realtime;
        if (frame_i < 4) begin
            if (bit_i < 8) cmd_cap[frame_i] = {cmd_cap[frame_i][6:0], mosi};
            else if (mosi) pad_ones++;
        end
        bit_i++; rises++;
    end

    always @(negedge sclk) begin
        if ($realtime - t_rise < hi_min) hi_min = $realtime - t_rise;
        if ($realtime - t_rise > hi_max) hi_max = $realtime - t_rise;
        if (bit_i == 16) begin frame_i++; bit_i = 0; end
        if (frame_i < 4) miso = resp[frame_i][15 - bit_i];
    end

    // ---------------- helpers ----------------
    task automatic chk(string req, string what, longint act, longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic set_values(logic [11:0] y, logic [11:0] x, logic [11:0] z1, logic [11:0] z2);
        resp[0] = enc(y); resp[1] = enc(x); resp[2] = enc(z1); resp[3] = enc(z2);
    endtask

    task automatic pulse_start();
        @(negedge clk) start_i = 1'b1;
        @(negedge clk) start_i = 1'b0;
    endtask

    task automatic wait_done(string req);
        int n = 0;
        while (!scan_done && n < 20000) begin @(negedge clk); n++; end
        chk(req, "scan_done seen", (n < 20000), 1);
    endtask

    task automatic accept();
        @(negedge clk) res_ready = 1'b1;
        @(negedge clk) res_ready = 1'b0;
    endtask

    // ---------------- scenarios ----------------
    task automatic t_reset();
        chk("R1", "cs_n", cs_n, 1);
        chk("R1", "sclk", sclk, 0);
        chk("R1", "res_valid", res_valid, 0);
        chk("R1", "overflow", overflow, 0);
        chk("R1", "scan_done", scan_done, 0);
        chk("R1", "res_x", res_x, 0);
    endtask

    task automatic t_basic();
        set_values(12'h5A3, 12'h7FF, 12'h123, 12'hABC);
        pulse_start();
        wait_done("R2");
        chk("R2", "cs falls", cs_falls, 1);
        chk("R2", "sclk rises", rises, 64);
        chk("R2", "cs_n after scan", cs_n, 1);
        chk("R3", "cmd Y", cmd_cap[0], 8'h93);
        chk("R3", "cmd X", cmd_cap[1], 8'hD3);
        chk("R3", "cmd Z1", cmd_cap[2], 8'hB3);
        chk("R3", "cmd Z2", cmd_cap[3], 8'hC0);
        chk("R3", "filler ones", pad_ones, 0);
        chk("R4", "min high ns", longint'(hi_min), SCLK_HALF * 4);
        chk("R4", "max high ns", longint'(hi_max), SCLK_HALF * 4);
        chk("R5", "res_y", res_y, 12'h5A3);
        chk("R5", "res_x", res_x, 12'h7FF);
        chk("R5", "res_z1", res_z1, 12'h123);
        chk("R5", "res_z2", res_z2, 12'hABC);
        chk("R6", "pressed", res_pressed, 1);
        chk("R7", "valid with done", res_valid, 1);
        repeat (20) @(negedge clk);
        chk("R7", "valid held", res_valid, 1);
        chk("R7", "x held", res_x, 12'h7FF);
        accept();
        chk("R7", "valid cleared", res_valid, 0);
    endtask

    task automatic t_out_of_range();
        set_values(12'h111, 12'd10, 12'h200, 12'h0F0);
        pulse_start();
        wait_done("R6");
        chk("R6", "pressed low x", res_pressed, 0);
        chk("R6", "x held", res_x, 12'h7FF);
        chk("R6", "y held", res_y, 12'h5A3);
        chk("R6", "z1 updated", res_z1, 12'h200);
        chk("R6", "z2 updated", res_z2, 12'h0F0);
        accept();
        set_values(12'h222, 12'h300, 12'h000, 12'h0F1);
        pulse_start();
        wait_done("R6");
        chk("R6", "pressed z1 zero", res_pressed, 0);
        chk("R6", "x held z1 zero", res_x, 12'h7FF);
        chk("R6", "z2 new", res_z2, 12'h0F1);
        accept();
    endtask

    task automatic t_pen();
        int base = cs_falls;
        int n = 0;
        @(negedge clk) pen_irq_n = 1'b0;
        repeat (50) @(negedge clk);
        pen_irq_n = 1'b1;
        repeat (400) @(negedge clk);
        chk("R8", "glitch ignored", cs_falls, base);
        set_values(12'h0AA, 12'h0BB, 12'h0CC, 12'h0DD);
        @(negedge clk) pen_irq_n = 1'b0;
        while (cs_n && n < 2000) begin @(negedge clk); n++; end
        pen_irq_n = 1'b1;
        chk("R8", "debounce window ok", (n >= DEB && n <= DEB + 4), 1);
        wait_done("R8");
        chk("R8", "pen scan x", res_x, 12'h0BB);
        chk("R8", "pen scan pressed", res_pressed, 1);
        accept();
    endtask

    task automatic t_busy();
        int base = cs_falls;
        set_values(12'h321, 12'h456, 12'h010, 12'h020);
        pulse_start();
        repeat (10) @(negedge clk);
        pen_irq_n = 1'b0;
        repeat (DEB * 2) @(negedge clk);
        pen_irq_n = 1'b1;
        pulse_start();
        repeat (100) @(negedge clk);
        pulse_start();
        wait_done("R9");
        accept();
        repeat (DEB * 3) @(negedge clk);
        chk("R9", "single scan", cs_falls - base, 1);
        chk("R9", "no new valid", res_valid, 0);
    endtask

    task automatic t_overflow();
        int base;
        set_values(12'h400, 12'h500, 12'h060, 12'h070);
        pulse_start();
        wait_done("R10");
        base = cs_falls;
        set_values(12'hFFF, 12'hFFF, 12'hFFF, 12'hFFF);
        pulse_start();
        repeat (300) @(negedge clk);
        chk("R10", "no scan while pending", cs_falls, base);
        chk("R10", "overflow set", overflow, 1);
        chk("R10", "result kept", res_x, 12'h500);
        accept();
        chk("R10", "overflow cleared", overflow, 0);
    endtask

    // Watchdog: a hung run counts as a failure and still reports
    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 4; i++) begin resp[i] = '0; cmd_cap[i] = '0; end
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_basic();
        t_out_of_range();
        t_pen();
        t_busy();
        t_overflow();
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule